// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This unit sits in the execute stage of an 8-bit accumulator processor. It decides whether a conditional relative branch is taken, and it forms the branch destination. The destination is the address of the following instruction plus a signed byte of displacement. The unit also works out the new carry flag and the decremented loop counter that the register file writes back. All four results are registered and appear together one clock after the operands are presented.

The decoder supplies a 2-bit branch kind, the accumulator, an operand byte and a comparison byte. The operand byte holds the loop counter for a decrement branch and the first compared byte for a compare branch. The status word has no zero flag, so the zero and non-zero tests look at the accumulator value directly. A compare branch also reports an unsigned less-than result through carry. A valid strobe marks the cycles that carry a branch. Every other cycle reports not-taken.

Top module: `brc_unit`

## Requirements
- R1: One cycle after a valid branch, `target_o` equals `next_pc_i` plus `disp_i` sign-extended to 16 bits, taken modulo 2^16. This gives a reach of -128 to +127 bytes, and the sum wraps past FFFFh and below 0000h.
- R2: Kind 0 (accumulator-zero test): `taken_o` is 1 exactly when `acc_i` is 00h.
- R3: Kind 1 (accumulator-non-zero test): `taken_o` is 1 exactly when `acc_i` is not 00h.
- R4: Kind 2 (decrement test): `dec_o` equals `opnd_i` minus one modulo 256, and `taken_o` is 1 exactly when that result is not 00h. An operand of 00h gives FFh and is taken. An operand of 01h gives 00h and is not taken.
- R5: Kind 3 (compare test): `taken_o` is 1 exactly when `opnd_i` differs from `cmpb_i`.
- R6: Kind 3 writes `carry_o` with 1 when `opnd_i` is below `cmpb_i` as unsigned numbers, and with 0 otherwise.
- R7: In every cycle that is not a valid kind-3 branch, `carry_o` takes the value of `carry_i`, so the carry passes through unchanged.
- R8: When `valid_i` is 0, `taken_o` is 0 in the next cycle, whatever the other inputs are.
- R9: While `rst_n` is low at a clock edge, all outputs are cleared to 0 (synchronous, active-low).
- R10: Every output reflects the inputs sampled at the previous rising clock edge, with a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | A branch is being evaluated this cycle |
| kind_i | input | 2 | Branch kind: 0 zero, 1 non-zero, 2 decrement, 3 compare |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Counter byte (kind 2) or first compared byte (kind 3) |
| cmpb_i | input | 8 | Second compared byte (kind 3) |
| disp_i | input | 8 | Signed displacement |
| next_pc_i | input | 16 | Address of the instruction after the branch |
| carry_i | input | 1 | Current carry flag |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch destination |
| carry_o | output | 1 | Carry flag for write-back |
| dec_o | output | 8 | Decremented counter for write-back |

## Verification
Every result (taken, destination, carry and decremented counter) is due exactly one rising edge after its inputs are driven. The bench therefore drives each operand set just after a falling edge. It then samples all four outputs shortly after the next rising edge, before the following falling edge changes the inputs. The bench sweeps every accumulator value for the zero tests, every counter value for the decrement test and every operand pair for the compare test. It runs every displacement against bases chosen near both ends of the address space. The reference model is plain arithmetic inside the bench.

// File: rtl/brc_pkg.sv
// Package: brc_pkg
// Shared encodings for the conditional branch evaluation unit.
// Assumes the decoder drives the 2-bit kind codes listed here.
package brc_pkg;

    typedef enum logic [1:0] {
        BR_ACC_ZERO = 2'd0,
        BR_ACC_NZ   = 2'd1,
        BR_DEC_NZ   = 2'd2,
        BR_CMP_NE   = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic take;       // branch condition holds
        logic carry_wr;   // kind writes the carry flag
        logic carry_val;  // value written to carry
    } br_flags_t;

endpackage

// File: rtl/brc_target.sv
// Module: brc_target
// Adds a sign-extended displacement to the base address.
// Assumes DISP_W < ADDR_W; the sum wraps modulo 2^ADDR_W.
module brc_target #(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    // Sign-extend the displacement to address width.
    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end

    // Wrapping address sum.
    always_comb begin
        tgt_o = base_i + disp_ext;
    end

endmodule

// File: rtl/brc_cond.sv
// Module: brc_cond
// Evaluates the branch condition, the decremented counter and the
// carry update for one branch kind. Purely combinational.
// Assumes opnd_i holds the counter for the decrement kind and the
// first compared byte for the compare kind.
module brc_cond
    import brc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  br_kind_e            kind_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic [DATA_W-1:0]   opnd_i,
    input  logic [DATA_W-1:0]   cmpb_i,
    output logic [DATA_W-1:0]   dec_o,
    output br_flags_t           flags_o
);
    logic acc_is_zero;
    logic dec_is_zero;
    logic bytes_differ;
    logic below;

    // Decrement the counter with modulo wrap.
    always_comb begin
        dec_o = opnd_i - DATA_W'(1);
    end

    // Raw comparisons shared by the kinds.
    always_comb begin
        acc_is_zero  = (acc_i == '0);
        dec_is_zero  = (dec_o == '0);
        bytes_differ = (opnd_i != cmpb_i);
        below        = (opnd_i < cmpb_i);
    end

    // Select the condition and carry behaviour per kind.
    always_comb begin
        flags_o = '{take: 1'b0, carry_wr: 1'b0, carry_val: 1'b0};
        unique case (kind_i)
            BR_ACC_ZERO: flags_o.take = acc_is_zero;
            BR_ACC_NZ:   flags_o.take = !acc_is_zero;
            BR_DEC_NZ:   flags_o.take = !dec_is_zero;
            BR_CMP_NE: begin
                flags_o.take      = bytes_differ;
                flags_o.carry_wr  = 1'b1;
                flags_o.carry_val = below;
            end
            default:     flags_o.take = 1'b0;
        endcase
    end

endmodule

// File: rtl/brc_unit.sv
// Module: brc_unit
// Top of the conditional branch evaluation unit. Registers the taken
// flag, destination, carry and decremented counter one cycle after
// the inputs. Assumes a synchronous active-low reset and that the
// decoder routes operands as described in the port list.
module brc_unit
    import brc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [1:0]        kind_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] cmpb_i,
    input  logic [DATA_W-1:0] disp_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic              carry_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              carry_o,
    output logic [DATA_W-1:0] dec_o
);
    localparam int EXT_W = ADDR_W - DATA_W;

    br_kind_e          kind;
    br_flags_t         flags;
    logic [DATA_W-1:0] dec_val;
    logic [ADDR_W-1:0] tgt_val;

    // Map the raw code onto the enumerated kind.
    always_comb begin
        kind = br_kind_e'(kind_i);
    end

    brc_cond #(.DATA_W(DATA_W)) u_cond (
        .kind_i  (kind),
        .acc_i   (acc_i),
        .opnd_i  (opnd_i),
        .cmpb_i  (cmpb_i),
        .dec_o   (dec_val),
        .flags_o (flags)
    );

    brc_target #(.ADDR_W(ADDR_W), .DISP_W(DATA_W)) u_tgt (
        .base_i (next_pc_i),
        .disp_i (disp_i),
        .tgt_o  (tgt_val)
    );

    // Result registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o  <= 1'b0;
            target_o <= '0;
            carry_o  <= 1'b0;
            dec_o    <= '0;
        end else begin
            taken_o  <= valid_i & flags.take;
            target_o <= tgt_val;
            carry_o  <= (valid_i & flags.carry_wr) ? flags.carry_val : carry_i;
            dec_o    <= dec_val;
        end
    end

    // ---------------- assertions ----------------
    p_idle_no_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !taken_o);

    p_zero_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd0) |=> (taken_o == ($past(acc_i) == '0)));

    p_nz_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd1) |=> (taken_o == ($past(acc_i) != '0)));

    p_dec_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd2) |=> (taken_o == (dec_o != '0)));

    p_dec_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (DATA_W'(dec_o + DATA_W'(1)) == $past(opnd_i)));

    p_cmp_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd3) |=> (taken_o == ($past(opnd_i) != $past(cmpb_i))));

    p_cmp_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind_i == 2'd3) |=> (carry_o == ($past(opnd_i) < $past(cmpb_i))));

    p_carry_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && kind_i == 2'd3) |=> (carry_o == $past(carry_i)));

    p_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (ADDR_W'(target_o - $past(next_pc_i)) ==
                     {{EXT_W{$past(disp_i[DATA_W-1])}}, $past(disp_i)}));

endmodule

// File: tb/tb_brc_unit.sv
`timescale 1ns/1ps
module tb_brc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  kind_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  opnd_i = '0;
    logic [7:0]  cmpb_i = '0;
    logic [7:0]  disp_i = '0;
    logic [15:0] next_pc_i = '0;
    logic        carry_i = 1'b0;
    logic        taken_o;
    logic [15:0] target_o;
    logic        carry_o;
    logic [7:0]  dec_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    brc_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .cmpb_i(cmpb_i), .disp_i(disp_i),
        .next_pc_i(next_pc_i), .carry_i(carry_i), .taken_o(taken_o),
        .target_o(target_o), .carry_o(carry_o), .dec_o(dec_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Drive one operand set after a falling edge, sample after the next rising edge (R10).
    task automatic step(input bit v, input logic [1:0] k, input logic [7:0] a,
                        input logic [7:0] o, input logic [7:0] c, input logic [7:0] d,
                        input logic [15:0] pc, input bit ci);
        logic [15:0] e_tgt;
        logic [7:0]  e_dec;
        bit          e_take;
        bit          e_carry;
        @(negedge clk);
        valid_i = v; kind_i = k; acc_i = a; opnd_i = o; cmpb_i = c;
        disp_i = d; next_pc_i = pc; carry_i = ci;
        e_tgt = pc + {{8{d[7]}}, d};
        e_dec = o - 8'd1;
        case (k)
            2'd0: e_take = (a == 8'd0);
            2'd1: e_take = (a != 8'd0);
            2'd2: e_take = (e_dec != 8'd0);
            default: e_take = (o != c);
        endcase
        e_take  = e_take & v;
        e_carry = (v && k == 2'd3) ? (o < c) : ci;
        @(posedge clk);
        #2;
        case (k)
            2'd0: chk(taken_o == e_take, v ? "R2" : "R8", taken_o, e_take);
            2'd1: chk(taken_o == e_take, v ? "R3" : "R8", taken_o, e_take);
            2'd2: chk(taken_o == e_take, v ? "R4" : "R8", taken_o, e_take);
            default: chk(taken_o == e_take, v ? "R5" : "R8", taken_o, e_take);
        endcase
        chk(target_o == e_tgt, "R1", target_o, e_tgt);
        chk(dec_o == e_dec, "R4", dec_o, e_dec);
        chk(carry_o == e_carry, (v && k == 2'd3) ? "R6" : "R7", carry_o, e_carry);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        // R9: reset clears everything even with live inputs
        valid_i = 1'b1; kind_i = 2'd3; opnd_i = 8'h05; cmpb_i = 8'h09;
        disp_i = 8'h40; next_pc_i = 16'h1234; carry_i = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(taken_o == 1'b0, "R9", taken_o, 0);
        chk(target_o == 16'h0, "R9", target_o, 0);
        chk(carry_o == 1'b0, "R9", carry_o, 0);
        chk(dec_o == 8'h0, "R9", dec_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2, R3: every accumulator value, both carry inputs (R7)
        for (int a = 0; a < 256; a++) begin
            step(1'b1, 2'd0, 8'(a), 8'(a * 7), 8'h11, 8'(a), 16'h8000, a[0]);
            step(1'b1, 2'd1, 8'(a), 8'(a + 3), 8'h22, 8'(a), 16'h0100, a[1]);
        end
        // R4: every counter value including 00h wrap and 01h stop
        for (int o = 0; o < 256; o++)
            step(1'b1, 2'd2, 8'h00, 8'(o), 8'h00, 8'h10, 16'h2000, o[2]);
        // R5, R6: every operand pair
        for (int o = 0; o < 256; o++)
            for (int c = 0; c < 256; c++)
                step(1'b1, 2'd3, 8'hFF, 8'(o), 8'(c), 8'h02, 16'h3000, c[0]);
        // R1: every displacement at both ends of the address space
        for (int d = 0; d < 256; d++) begin
            step(1'b1, 2'd0, 8'h01, 8'h00, 8'h00, 8'(d), 16'hFFF0, 1'b0);
            step(1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 8'(d), 16'h0010, 1'b1);
            step(1'b1, 2'd2, 8'h00, 8'h05, 8'h00, 8'(d), 16'h7F80, 1'b0);
        end
        // R8, R7: no valid, all kinds with conditions that would take
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 2'(k), 8'h00, 8'h00, 8'h01, 8'h7F, 16'hABCD, 1'b1);
            step(1'b0, 2'(k), 8'h55, 8'h03, 8'h09, 8'h80, 16'h0000, 1'b0);
        end
        done = 1'b1;
        summary();
    end
endmodule